// File: doc/BRIEF.md
# 2D Rectangle Fill and Copy Engine

This block is a small drawing engine for a linear framebuffer in which every pixel is one 32-bit word. Software programs a handful of registers over a write-only register bus: the operation and walk directions, a brush colour, a bit write mask, packed source and destination start points, the screen size, the line pitch and the framebuffer base. Writing the size register launches the operation. The engine then walks the rectangle pixel by pixel and issues requests to a single-port synchronous memory. A fill sends only writes. A copy sends a read of the source pixel followed by a write of that value to the destination.

Each axis has its own direction bit. A copy whose destination overlaps its own source is therefore safe: software walks from the far corner on any axis where the source lies before the destination. Requests that cannot touch the screen are discarded before any memory access. Rectangles that run off the right or bottom edge are trimmed to the visible area. A busy output tells software when the engine can take a new command.

Top module: `blit2d`

## Requirements
- R1: After reset `busy` and `memReq` are low. The register addresses are: 0 control, 1 brush colour, 2 write mask, 3 source start, 4 destination start, 5 screen size, 6 pitch, 7 base, 8 size. A write to address 8 starts an operation, and `busy` is high in the cycle after that write unless the request is discarded (R8).
- R2: Source start, destination start and screen size are packed words with the Y value (or Y resolution) in bits 31:16 and the X value (or X resolution) in bits 15:0. The pitch is taken from bits 15:0 of its register.
- R3: In fill mode the size word carries width in bits 31:16 and height in bits 15:0. In copy mode it carries height in bits 31:16 and width in bits 15:0.
- R4: A fill writes the brush colour once to every pixel of the rectangle at word address base + y*pitch + x. X advances fastest, and the row steps after the last column.
- R5: Control bit 0 set selects copy. Each pixel is then a read at the source address followed by a write of the returned value, unchanged, to the destination address.
- R6: Control bit 1 set walks X upward from the start, and clear walks it downward. Control bit 2 does the same for Y. With downward walks and the start points placed on the far column or row, an overlapping copy produces the same image as a copy from an untouched source.
- R7: Every write carries the write mask register on `memWmask`. Memory bits whose mask bit is 0 keep their old value.
- R8: A request with zero width, zero height, a destination start at or beyond the screen X or Y size, or (for copy) a source start at or beyond it, makes no memory access and leaves `busy` low.
- R9: When the rectangle runs past the screen, width becomes the smaller of the requested width, xres minus destination X and, for copy, xres minus source X. Height is trimmed the same way against yres.
- R10: `busy` stays high until the last pixel write is granted. Register writes made while busy have no effect on the current or any later operation.
- R11: A memory request holds its address and direction until `memGnt` is seen. Only one request is outstanding, and a read waits for `memRvalid` before the next request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write (1) or read (0) |
| memAddr | output | MEM_AW | Pixel word address |
| memWdata | output | 32 | Pixel write data |
| memWmask | output | 32 | Per-bit write enable |
| memGnt | input | 1 | Memory accepts the current request |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |

## Verification
The assertions take for granted that the memory grants only a request that is present and returns exactly one read response for each granted read, some cycles later. They also assume that the size write is the only way software raises `busy`. The bench memory grants with a repeating stall pattern, answers a granted read on the following cycle, and never answers when no read is pending. Register writes issued while the engine runs are deliberate stimulus that the design must ignore, and they fall within what the assertions allow.

// File: rtl/blit2d_pkg.sv
package blit2d_pkg;
  localparam int WORD_W  = 32;
  localparam int COORD_W = WORD_W / 2;
  localparam int REG_AW  = 4;

  typedef logic [REG_AW-1:0] regAddr_t;

  localparam regAddr_t A_CTRL   = 4'd0;
  localparam regAddr_t A_COLOR  = 4'd1;
  localparam regAddr_t A_MASK   = 4'd2;
  localparam regAddr_t A_SRC    = 4'd3;
  localparam regAddr_t A_DST    = 4'd4;
  localparam regAddr_t A_SCREEN = 4'd5;
  localparam regAddr_t A_PITCH  = 4'd6;
  localparam regAddr_t A_BASE   = 4'd7;
  localparam regAddr_t A_SIZE   = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic step;
    logic selDst;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_RWAIT,
    ST_WRITE
  } walkState_t;
endpackage

// File: rtl/blit2d_dp.sv
module blit2d_dp
  import blit2d_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  regAddr_t          regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              busy,
  input  ctlStrobes_t       strb,
  input  logic [WORD_W-1:0] memRdata,
  output logic              isCopy,
  output logic              goReq,
  output logic              lastPix,
  output logic [MEM_AW-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] memWmask
);
  localparam int PROD_W = 2 * COORD_W;

  logic                opCopy, xInc, yInc;
  logic [WORD_W-1:0]   brushColor, wrMask, pixReg;
  logic [COORD_W-1:0]  srcX, srcY, dstX, dstY, xRes, yRes, pitch;
  logic [MEM_AW-1:0]   fbBase;
  logic [COORD_W-1:0]  wReg, hReg, colCnt, rowCnt;
  logic [COORD_W-1:0]  wRaw, hRaw, wClip, hClip;
  logic                sizeWr, dropReq, regOpen;

  assign regOpen = regWrEn && !busy;
  assign sizeWr  = regOpen && (regAddr == A_SIZE);

  // register file, frozen while busy (R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCopy     <= 1'b0;
      xInc       <= 1'b1;
      yInc       <= 1'b1;
      brushColor <= '0;
      wrMask     <= '1;
      srcX       <= '0;
      srcY       <= '0;
      dstX       <= '0;
      dstY       <= '0;
      xRes       <= '0;
      yRes       <= '0;
      pitch      <= '0;
      fbBase     <= '0;
    end else if (regOpen) begin
      case (regAddr)
        A_CTRL:   {yInc, xInc, opCopy} <= regWrData[2:0];
        A_COLOR:  brushColor <= regWrData;
        A_MASK:   wrMask <= regWrData;
        A_SRC:    {srcY, srcX} <= regWrData;
        A_DST:    {dstY, dstX} <= regWrData;
        A_SCREEN: {yRes, xRes} <= regWrData;
        A_PITCH:  pitch <= regWrData[COORD_W-1:0];
        A_BASE:   fbBase <= regWrData[MEM_AW-1:0];
        default:  ;
      endcase
    end
  end

  // size decode, discard and trim (R3, R8, R9)
  always_comb begin
    wRaw = opCopy ? regWrData[COORD_W-1:0] : regWrData[WORD_W-1:COORD_W];
    hRaw = opCopy ? regWrData[WORD_W-1:COORD_W] : regWrData[COORD_W-1:0];
    dropReq = (wRaw == '0) || (hRaw == '0) || (dstX >= xRes) || (dstY >= yRes) ||
              (opCopy && ((srcX >= xRes) || (srcY >= yRes)));
    wClip = wRaw;
    hClip = hRaw;
    if (({1'b0, dstX} + {1'b0, wClip}) > {1'b0, xRes}) wClip = xRes - dstX;
    if (({1'b0, dstY} + {1'b0, hClip}) > {1'b0, yRes}) hClip = yRes - dstY;
    if (opCopy) begin
      if (({1'b0, srcX} + {1'b0, wClip}) > {1'b0, xRes}) wClip = xRes - srcX;
      if (({1'b0, srcY} + {1'b0, hClip}) > {1'b0, yRes}) hClip = yRes - srcY;
    end
  end

  assign goReq  = sizeWr && !dropReq;
  assign isCopy = opCopy;

  // walk counters: column fastest, then row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wReg   <= '0;
      hReg   <= '0;
      colCnt <= '0;
      rowCnt <= '0;
    end else if (strb.load) begin
      wReg   <= wClip;
      hReg   <= hClip;
      colCnt <= '0;
      rowCnt <= '0;
    end else if (strb.step) begin
      if (colCnt == wReg - 1'b1) begin
        colCnt <= '0;
        rowCnt <= rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pixReg <= '0;
    else if (strb.capture) pixReg <= memRdata;
  end

  assign lastPix = (colCnt == wReg - 1'b1) && (rowCnt == hReg - 1'b1);

  function automatic logic [MEM_AW-1:0] pixAddr(input logic [COORD_W-1:0] px,
                                                input logic [COORD_W-1:0] py);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(py) * PROD_W'(pitch);
    return fbBase + MEM_AW'(prod) + MEM_AW'(px);
  endfunction

  logic [COORD_W-1:0] curSx, curSy, curDx, curDy;
  always_comb begin
    curSx = xInc ? srcX + colCnt : srcX - colCnt;
    curDx = xInc ? dstX + colCnt : dstX - colCnt;
    curSy = yInc ? srcY + rowCnt : srcY - rowCnt;
    curDy = yInc ? dstY + rowCnt : dstY - rowCnt;
  end

  assign memAddr  = strb.selDst ? pixAddr(curDx, curDy) : pixAddr(curSx, curSy);
  assign memWdata = opCopy ? pixReg : brushColor;
  assign memWmask = wrMask;
endmodule

// File: rtl/blit2d_ctl.sv
module blit2d_ctl
  import blit2d_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        goReq,
  input  logic        isCopy,
  input  logic        lastPix,
  input  logic        memGnt,
  input  logic        memRvalid,
  output ctlStrobes_t strb,
  output logic        busy,
  output logic        memReq,
  output logic        memWe
);
  walkState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt    = state;
    strb   = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (goReq) begin
          strb.load = 1'b1;
          nxt = isCopy ? ST_READ : ST_WRITE;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memGnt) nxt = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (memRvalid) begin
          strb.capture = 1'b1;
          nxt = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        strb.selDst = 1'b1;
        if (memGnt) begin
          strb.step = 1'b1;
          if (lastPix)     nxt = ST_IDLE;
          else if (isCopy) nxt = ST_READ;
          else             nxt = ST_WRITE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/blit2d.sv
module blit2d
  import blit2d_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       memWmask,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [31:0]       memRdata
);
  ctlStrobes_t strb;
  logic        isCopy, goReq, lastPix;

  blit2d_dp #(.MEM_AW(MEM_AW)) dp_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .busy(busy), .strb(strb), .memRdata(memRdata),
    .isCopy(isCopy), .goReq(goReq), .lastPix(lastPix),
    .memAddr(memAddr), .memWdata(memWdata), .memWmask(memWmask)
  );

  blit2d_ctl ctl_i (
    .clk(clk), .rstN(rstN),
    .goReq(goReq), .isCopy(isCopy), .lastPix(lastPix),
    .memGnt(memGnt), .memRvalid(memRvalid),
    .strb(strb), .busy(busy), .memReq(memReq), .memWe(memWe)
  );
endmodule

// File: rtl/blit2d_chk.sv
module blit2d_chk
  import blit2d_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [3:0]        regAddr,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic              memGnt,
  input logic [MEM_AW-1:0] memAddr,
  input logic [31:0]       memWmask
);
  AST_START_BY_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && (regAddr == A_SIZE))); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R8

  AST_BUSY_TO_LAST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(memReq && memWe && memGnt)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R11

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memWmask)); // R7
endmodule

bind blit2d blit2d_chk #(.MEM_AW(MEM_AW)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .busy(busy), .memReq(memReq), .memWe(memWe), .memGnt(memGnt),
  .memAddr(memAddr), .memWmask(memWmask)
);

// File: tb/blit2d_tb_top.sv
`timescale 1ns/1ps
module blit2d_tb_top;
  import blit2d_pkg::*;

  localparam int MEM_AW = 20;
  localparam int MEMW   = 4096;
  localparam int XRES = 40, YRES = 30, PITCH = 48, BASE = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic busy, memReq, memWe;
  logic [MEM_AW-1:0] memAddr;
  logic [31:0] memWdata, memWmask;
  logic memGnt = 1'b0, memRvalid = 1'b0;
  logic [31:0] memRdata = '0;

  always #2.5 clk = ~clk;

  blit2d #(.MEM_AW(MEM_AW)) dut_i (.*);

  typedef struct {
    logic [MEM_AW-1:0] a;
    logic [31:0] d;
    logic [31:0] m;
  } item_t;
  item_t expQ[$];

  logic [31:0] mem[MEMW];
  logic [31:0] shadow[MEMW];
  logic [31:0] pre[MEMW];
  int checks = 0, failures = 0, cyc = 0, wrCount = 0;
  bit rvPend = 0;
  logic [MEM_AW-1:0] rvAddr;
  logic [31:0] bColor, bMask;
  string curTag = "R4";

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    memRvalid = 1'b0;
    if (rvPend) begin
      memRvalid = 1'b1;
      memRdata  = mem[rvAddr[11:0]];
      rvPend    = 0;
    end
    memGnt = memReq && (cyc % 3 != 1);
    if (memGnt && !memWe) begin
      rvPend = 1;
      rvAddr = memAddr;
    end
    if (memGnt && memWe) begin
      wrCount++;
      mem[memAddr[11:0]] = (mem[memAddr[11:0]] & ~memWmask) | (memWdata & memWmask);
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected write addr=%0d data=%h expected none", curTag, memAddr, memWdata);
      end else begin
        item_t e;
        e = expQ.pop_front();
        if (e.a !== memAddr || e.d !== memWdata || e.m !== memWmask) begin
          failures++;
          $display("FAIL %s write addr=%0d data=%h mask=%h expected addr=%0d data=%h mask=%h",
                   curTag, memAddr, memWdata, memWmask, e.a, e.d, e.m);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWr(input regAddr_t a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // reference walk: fills expected queue and shadow memory
  task automatic planOp(input bit cp, input bit xi, input bit yi,
                        input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, output bit dropped);
    int cw = w, ch = h;
    dropped = (w == 0) || (h == 0) || (dx >= XRES) || (dy >= YRES) ||
              (cp && ((sx >= XRES) || (sy >= YRES)));
    if (dropped) return;
    if (dx + cw > XRES) cw = XRES - dx;
    if (dy + ch > YRES) ch = YRES - dy;
    if (cp && sx + cw > XRES) cw = XRES - sx;
    if (cp && sy + ch > YRES) ch = YRES - sy;
    for (int r = 0; r < ch; r++) begin
      for (int c = 0; c < cw; c++) begin
        int x, y, u, v, da, sa;
        item_t it;
        x = xi ? dx + c : dx - c;
        y = yi ? dy + r : dy - r;
        u = xi ? sx + c : sx - c;
        v = yi ? sy + r : sy - r;
        da = BASE + y * PITCH + x;
        sa = BASE + v * PITCH + u;
        it.a = MEM_AW'(da);
        it.d = cp ? shadow[sa] : bColor;
        it.m = bMask;
        shadow[da] = (shadow[da] & ~bMask) | (it.d & bMask);
        expQ.push_back(it);
      end
    end
  endtask

  bit lastDrop;
  int wrBefore;

  task automatic startOp(input string tag, input bit cp, input bit xi, input bit yi,
                         input int sx, input int sy, input int dx, input int dy,
                         input int w, input int h);
    curTag = tag;
    for (int i = 0; i < MEMW; i++) pre[i] = mem[i];
    wrBefore = wrCount;
    regWr(A_CTRL, {29'd0, yi, xi, cp});
    regWr(A_SRC, {sy[15:0], sx[15:0]});
    regWr(A_DST, {dy[15:0], dx[15:0]});
    planOp(cp, xi, yi, sx, sy, dx, dy, w, h, lastDrop);
    regWr(A_SIZE, cp ? {h[15:0], w[15:0]} : {w[15:0], h[15:0]});
    chk(busy == !lastDrop, {tag, " busy after size write (R1)"}, busy, !lastDrop);
  endtask

  task automatic finishOp(input string tag);
    int n = 0;
    int diffs = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(!busy, {tag, " idle at end (R10)"}, busy, 0);
    chk(expQ.size() == 0, {tag, " all expected writes seen"}, expQ.size(), 0);
    expQ.delete();
    if (lastDrop) chk(wrCount == wrBefore, {tag, " no access on discard (R8)"}, wrCount - wrBefore, 0);
    for (int i = 0; i < MEMW; i++) if (mem[i] !== shadow[i]) diffs++;
    chk(diffs == 0, {tag, " memory image with mask merge (R7)"}, diffs, 0);
  endtask

  task automatic runOp(input string tag, input bit cp, input bit xi, input bit yi,
                       input int sx, input int sy, input int dx, input int dy,
                       input int w, input int h);
    startOp(tag, cp, xi, yi, sx, sy, dx, dy, w, h);
    finishOp(tag);
  endtask

  // overlap result must equal a copy from the untouched source
  task automatic ovlCheck(input int sl, input int st, input int dl, input int dt,
                          input int w, input int h);
    int bad = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        if (mem[BASE + (dt + r) * PITCH + dl + c] !== pre[BASE + (st + r) * PITCH + sl + c]) bad++;
    chk(bad == 0, "R6 overlap copy image", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      shadow[i] = mem[i];
    end
    bColor = 32'h0;
    bMask  = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && memReq == 0, "R1 reset state idle", {busy, memReq}, 0);

    regWr(A_SCREEN, {16'(YRES), 16'(XRES)});   // R2 packed screen size
    regWr(A_PITCH, PITCH);
    regWr(A_BASE, BASE);
    regWr(A_MASK, bMask);
    bColor = 32'hC0FF_EE01;
    regWr(A_COLOR, bColor);

    runOp("R4 fill incr", 0, 1, 1, 0, 0, 2, 4, 5, 3);
    runOp("R3 fill tall", 0, 1, 1, 0, 0, 30, 1, 2, 6);
    runOp("R6 fill decr", 0, 0, 0, 0, 0, 20, 12, 4, 3);

    bMask = 32'h0000_FFFF;
    regWr(A_MASK, bMask);
    bColor = 32'h1234_ABCD;
    regWr(A_COLOR, bColor);
    runOp("R7 fill masked", 0, 1, 1, 0, 0, 10, 10, 3, 2);
    bMask = 32'hFFFF_FFFF;
    regWr(A_MASK, bMask);

    runOp("R5 copy apart", 1, 1, 1, 0, 20, 25, 20, 8, 3);

    startOp("R6 copy overlap decr", 1, 0, 0, 10, 8, 12, 9, 6, 4);
    finishOp("R6 copy overlap decr");
    ovlCheck(5, 5, 7, 6, 6, 4);

    startOp("R6 copy overlap incr", 1, 1, 1, 12, 14, 9, 12, 7, 5);
    finishOp("R6 copy overlap incr");
    ovlCheck(12, 14, 9, 12, 7, 5);

    runOp("R9 fill trim", 0, 1, 1, 0, 0, 36, 27, 10, 10);
    runOp("R9 copy trim", 1, 1, 1, 35, 2, 30, 25, 8, 8);

    runOp("R8 zero width", 0, 1, 1, 0, 0, 1, 3, 0, 3);
    runOp("R8 dst x out", 0, 1, 1, 0, 0, 40, 3, 2, 2);
    runOp("R8 src y out", 1, 1, 1, 2, 30, 3, 3, 2, 2);
    runOp("R8 zero height", 1, 1, 1, 2, 2, 9, 9, 3, 0);

    // R10: writes while busy are ignored now and later
    bColor = 32'hA5A5_0F0F;
    regWr(A_COLOR, bColor);
    startOp("R10 busy ignore", 0, 1, 1, 0, 0, 0, 0, 20, 10);
    regWr(A_COLOR, 32'hDEAD_BEEF);
    regWr(A_MASK, 32'h0);
    regWr(A_DST, {16'd1, 16'd1});
    finishOp("R10 busy ignore");
    regWr(A_CTRL, 32'd6);
    planOp(0, 1, 1, 0, 0, 0, 0, 2, 2, lastDrop);
    wrBefore = wrCount;
    for (int i = 0; i < MEMW; i++) pre[i] = mem[i];
    regWr(A_SIZE, {16'd2, 16'd2});
    chk(busy == 1, "R10 later op starts", busy, 1);
    finishOp("R10 later op keeps old regs");

    // R11: copy made of reads and writes under stalls leaves no request pending
    runOp("R11 copy under stalls", 1, 1, 1, 3, 3, 20, 3, 4, 2);
    chk(memReq == 0 && !rvPend, "R11 no outstanding request", memReq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule